// File: doc/BRIEF.md
# Two-Clock Stream FIFO with Retransmit

This block moves 36-bit words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. Both sides are valid/ready streams. A word is accepted on a `wr_clk` rising edge when `wr_valid` and `wr_ready` are both high. It is delivered on a `rd_clk` rising edge when `rd_valid` and `rd_ready` are both high. `wr_ready` never depends on `wr_valid`, and `rd_valid` never depends on `rd_ready`. A producer that sees `wr_ready` low must hold its word and wait. A consumer that holds `rd_ready` low keeps the same word offered until it takes it. The one exception is a retransmit load, which can replace the offered word.

Each side has a level flag, `almost_empty` on the read side and `almost_full` on the write side. Pointers cross between the clocks as Gray code through a chain of synchronizer flops. The depth must be a power of two.

Retransmit lets the consumer replay data. Raising `rt_mode` captures a restart point (the shadow pointer) on the next `rd_clk` edge. While the mode is active, a `rd_clk` edge with `rt_load` high moves the read position back to that point, so the words after it are delivered again. While the mode is active, the write side counts free space from the shadow pointer, so replayable words are never overwritten. When the mode ends, the write side is moved forward to the live read position.

Top module: `dcf_rtx_fifo`

## Requirements
- R1: During and right after reset, `rd_valid` is 0, `wr_ready` is 1, `almost_empty` is 1 and `almost_full` is 0.
- R2: Words come out in the order they were accepted, each exactly once outside retransmit, with no word lost or altered.
- R3: After DEPTH words are held, `wr_ready` is 0. A write offered while `wr_ready` is 0 stores nothing.
- R4: `rd_valid` is 0 once every accepted word has been delivered, and `rd_valid` is never 1 without an undelivered word. Read attempts while `rd_valid` is 0 change nothing.
- R5: Once the pointers have settled, `almost_empty` is 1 exactly when the number of held words is at most AE_LVL.
- R6: Once the pointers have settled, `almost_full` is 1 exactly when the free space is at most AF_LVL.
- R7: While retransmit is active, a `rd_clk` edge with `rt_load` high sets the read position to the shadow pointer, and no word is consumed on that edge. `rd_valid` and `rd_data` show the new position right after that same edge, with no synchronizer delay.
- R8: If a load lifts the level above AE_LVL, `almost_empty` falls within two `rd_clk` edges after the load edge.
- R9: While retransmit is active, `wr_ready` and `almost_full` count free space from the shadow pointer, even after the consumer has read past it. After the mode ends, the space that was read is freed again.
- R10: Space freed by ending retransmit does not show up on `wr_ready` at the first `wr_clk` edge after the exit edge. It needs at least two `wr_clk` synchronizing edges.
- R11: `rt_load` has no effect when retransmit is not active.
- R12: The shadow pointer is set to the read position on the `rd_clk` edge that starts retransmit (after any read on that edge), and it does not change while the mode stays on. Repeated loads return to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can take a word |
| wr_data | input | WIDTH | Word to store |
| almost_full | output | 1 | Free space is at most AF_LVL |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_valid | output | 1 | A word is offered on `rd_data` |
| rd_ready | input | 1 | Consumer takes the offered word |
| rd_data | output | WIDTH | Word at the read position |
| almost_empty | output | 1 | Held words are at most AE_LVL |
| rt_mode | input | 1 | Retransmit mode request (level) |
| rt_load | input | 1 | Reload the read position from the shadow pointer |

## Verification
The bench replays the retransmit corner cases against a behavioural queue. In one case it reads to empty inside the mode and then loads. A design that waited on the synchronizer would keep `rd_valid` low for a cycle, and a wrong pointer copy would show the wrong word. It loads twice to catch a shadow pointer that drifts with reads. It also pulses `rt_load` outside the mode, where a design that ignored the gate would rewind.

On the write side, it fills the FIFO inside retransmit and drains it. A design that freed space from the live pointer would raise `wr_ready` and overwrite words that must be replayable. After exit it checks that the freed space is not visible at the very next `wr_clk` edge. The level flags are checked at exactly AE_LVL and AF_LVL and one word past them, which catches off-by-one comparisons.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Retransmit phase seen on a read-clock edge: {mode active now, mode requested}
  typedef enum logic [1:0] {
    RT_OFF   = 2'b00,
    RT_ENTER = 2'b01,
    RT_EXIT  = 2'b10,
    RT_ON    = 2'b11
  } rt_phase_e;

endpackage

// File: rtl/dcf_sync.sv
// Multi-stage synchronizer for a Gray-coded pointer, converted to binary
// on the destination side.
module dcf_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= gray_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_g2b
    assign bin_out[b] = ^(stg[STAGES-1][W-1:b]);
  end

endmodule

// File: rtl/dcf_ram.sv
// Storage array: synchronous write, asynchronous read.
module dcf_ram #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-side control: write pointer, full and almost-full against the
// synchronized read-side source pointer.
module dcf_wr_ctl #(
  parameter int DEPTH  = 512,
  parameter int AF_LVL = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [PW-1:0] wptr_gray,
  input  logic [PW-1:0] src_bin,
  output logic          almost_full
);

  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] AF_FREE  = PW'(AF_LVL);

  logic [PW-1:0] wptr, wptr_nxt, level, level_nxt;
  logic          fire;

  assign level     = wptr - src_bin;
  assign wr_ready  = (level != FULL_LVL);
  assign fire      = wr_valid && wr_ready;
  assign wptr_nxt  = wptr + PW'(fire);
  assign level_nxt = wptr_nxt - src_bin;
  assign mem_we    = fire;
  assign mem_waddr = wptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr        <= '0;
      wptr_gray   <= '0;
      almost_full <= 1'b0;
    end else begin
      wptr        <= wptr_nxt;
      wptr_gray   <= wptr_nxt ^ (wptr_nxt >> 1);
      almost_full <= (FULL_LVL - level_nxt) <= AF_FREE;
    end
  end

  // R3: stored words never exceed the depth counted from the source pointer
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  // R3: a refused offer leaves the write pointer where it was
  p_hold_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wptr == $past(wptr)));

endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-side control: live and shadow read pointers, retransmit phases,
// empty and almost-empty, and the source pointer sent to the write side.
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int AE_LVL = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  output logic          rd_valid,
  input  logic          rt_mode,
  input  logic          rt_load,
  output logic [AW-1:0] mem_raddr,
  input  logic [PW-1:0] wq_bin,
  output logic [PW-1:0] src_gray,
  output logic          almost_empty
);

  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] AE_WORDS = PW'(AE_LVL);

  logic [PW-1:0] rptr, rptr_nxt, sptr, sptr_nxt, src, src_nxt, target;
  logic          rt_act, load, fire;
  rt_phase_e     phase;

  assign phase    = rt_phase_e'({rt_act, rt_mode});
  assign load     = rt_act && rt_load;
  assign rd_valid = (rptr != wq_bin);
  assign fire     = rd_valid && rd_ready && !load;

  assign rptr_nxt = load ? sptr : (rptr + PW'(fire));
  assign sptr_nxt = (phase == RT_ENTER) ? rptr_nxt : sptr;

  // Source for the write side: shadow while the mode stays on, live otherwise.
  // It walks one step per edge so that each Gray update flips a single bit.
  assign target   = rt_mode ? sptr_nxt : rptr_nxt;
  assign src_nxt  = (src != target) ? (src + PW'(1)) : src;

  assign mem_raddr = rptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr         <= '0;
      sptr         <= '0;
      src          <= '0;
      src_gray     <= '0;
      rt_act       <= 1'b0;
      almost_empty <= 1'b1;
    end else begin
      rptr         <= rptr_nxt;
      sptr         <= sptr_nxt;
      src          <= src_nxt;
      src_gray     <= src_nxt ^ (src_nxt >> 1);
      rt_act       <= rt_mode;
      almost_empty <= (wq_bin - rptr_nxt) <= AE_WORDS;
    end
  end

  // R4: the read position never passes the synchronized write pointer
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_bin - rptr) <= FULL_LVL);

  // R7: a load in retransmit mode lands on the shadow pointer
  p_load_to_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_act && rt_load) |=> (rptr == $past(sptr)));

  // R12: the shadow pointer holds while the mode stays on
  p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_act && rt_mode) |=> $stable(sptr));

  // R9: the write-side source moves by at most one step per edge
  p_src_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src == $past(src)) || (src == $past(src) + PW'(1))));

  // R9: the write-side source never runs ahead of the live read position
  p_src_behind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr - src) <= FULL_LVL);

endmodule

// File: rtl/dcf_rtx_fifo.sv
// Two-clock stream FIFO with retransmit.
module dcf_rtx_fifo #(
  parameter int WIDTH       = 36,
  parameter int DEPTH       = 512,
  parameter int AE_LVL      = 8,
  parameter int AF_LVL      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  output logic             almost_full,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             almost_empty,
  input  logic             rt_mode,
  input  logic             rt_load
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [PW-1:0] wptr_gray, wq_bin, src_gray, src_bin;

  dcf_wr_ctl #(.DEPTH(DEPTH), .AF_LVL(AF_LVL)) u_wr (
    .clk        (wr_clk),
    .rst_n      (wr_rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .wptr_gray  (wptr_gray),
    .src_bin    (src_bin),
    .almost_full(almost_full)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH), .AE_LVL(AE_LVL)) u_rd (
    .clk         (rd_clk),
    .rst_n       (rd_rst_n),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .rt_mode     (rt_mode),
    .rt_load     (rt_load),
    .mem_raddr   (mem_raddr),
    .wq_bin      (wq_bin),
    .src_gray    (src_gray),
    .almost_empty(almost_empty)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk    (rd_clk),
    .rst_n  (rd_rst_n),
    .gray_in(wptr_gray),
    .bin_out(wq_bin)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk    (wr_clk),
    .rst_n  (wr_rst_n),
    .gray_in(src_gray),
    .bin_out(src_bin)
  );

  dcf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .wclk (wr_clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(wr_data),
    .raddr(mem_raddr),
    .rdata(rd_data)
  );

endmodule

// File: tb/tb_dcf_rtx_fifo.sv
module tb_dcf_rtx_fifo;

  localparam int W     = 36;
  localparam int DEPTH = 32;
  localparam int AE    = 4;
  localparam int AF    = 4;

  logic         wr_clk = 0, rd_clk = 0;
  logic         wr_rst_n = 0, rd_rst_n = 0;
  logic         wr_valid = 0, wr_ready;
  logic [W-1:0] wr_data = '0;
  logic         almost_full;
  logic         rd_valid, rd_ready = 0;
  logic [W-1:0] rd_data;
  logic         almost_empty;
  logic         rt_mode = 0, rt_load = 0;

  dcf_rtx_fifo #(.WIDTH(W), .DEPTH(DEPTH), .AE_LVL(AE), .AF_LVL(AF)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .almost_full(almost_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .almost_empty(almost_empty),
    .rt_mode(rt_mode), .rt_load(rt_load)
  );

  always #5 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  // Reference model
  logic [W-1:0] hist[$];
  int rd_idx = 0, sh_idx = 0;
  bit rt_act_m = 0;

  // Stimulus controls: 0 idle, 1 random, 2 always, 3 budget
  int wr_mode = 0, rd_mode = 0, wr_budget = 0, rd_budget = 0;
  bit rt_cmd = 0, load_req = 0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Write engine with per-cycle model checks
  always @(negedge wr_clk) begin
    int base;
    base = rt_act_m ? sh_idx : rd_idx;
    if (wr_rst_n && wr_ready)
      chk((hist.size() - base) < DEPTH, "R3/R9 ready with no free space",
          64'(hist.size() - base), 64'(DEPTH - 1));
    case (wr_mode)
      1: wr_valid = ($urandom % 3) != 0;
      2: wr_valid = 1'b1;
      3: wr_valid = (wr_budget > 0);
      default: wr_valid = 1'b0;
    endcase
    wr_data = {$urandom, $urandom} & {W{1'b1}};
    if (wr_rst_n && wr_valid && wr_ready) begin
      hist.push_back(wr_data);
      if (wr_mode == 3) wr_budget--;
    end
  end

  // Read engine with per-cycle model checks
  always @(negedge rd_clk) begin
    bit ld;
    if (rd_rst_n && rd_valid) begin
      if (rd_idx >= hist.size())
        chk(1'b0, "R4 valid with nothing held", 64'(rd_idx), 64'(hist.size()));
      else
        chk(rd_data == hist[rd_idx], "R2 data order", 64'(rd_data), 64'(hist[rd_idx]));
    end
    case (rd_mode)
      1: rd_ready = ($urandom % 3) != 0;
      2: rd_ready = 1'b1;
      3: rd_ready = (rd_budget > 0);
      default: rd_ready = 1'b0;
    endcase
    rt_mode = rt_cmd;
    rt_load = load_req;
    load_req = 0;
    if (rd_rst_n) begin
      ld = rt_act_m && rt_load;
      if (ld) rd_idx = sh_idx;
      else if (rd_valid && rd_ready) begin
        rd_idx++;
        if (rd_mode == 3) rd_budget--;
      end
      if (rt_mode && !rt_act_m) sh_idx = rd_idx;
      rt_act_m = rt_mode;
    end
  end

  task automatic settle(input int n);
    wr_mode = 0;
    rd_mode = 0;
    repeat (n) @(negedge rd_clk);
    #1;
  endtask

  task automatic write_n(input int n);
    wr_budget = n;
    wr_mode = 3;
    while (wr_budget > 0) @(negedge wr_clk);
    settle(12);
  endtask

  task automatic read_n(input int n);
    rd_budget = n;
    rd_mode = 3;
    while (rd_budget > 0) @(negedge rd_clk);
    settle(12);
  endtask

  task automatic do_load();
    @(negedge rd_clk);
    #1;
    load_req = 1;
    @(negedge rd_clk);   // load driven here, applied on the next rd edge
    @(negedge rd_clk);
    #1;
  endtask

  initial begin
    int st;
    repeat (5) @(negedge wr_clk);
    #1;
    // R1: reset values
    chk(rd_valid == 0, "R1 rd_valid", 64'(rd_valid), 0);
    chk(wr_ready == 1, "R1 wr_ready", 64'(wr_ready), 1);
    chk(almost_empty == 1, "R1 almost_empty", 64'(almost_empty), 1);
    chk(almost_full == 0, "R1 almost_full", 64'(almost_full), 0);
    wr_rst_n = 1;
    rd_rst_n = 1;
    settle(4);
    chk(rd_valid == 0 && wr_ready == 1, "R1 after release", 64'({rd_valid, wr_ready}), 64'b01);

    // R2: random traffic in both directions
    wr_mode = 1;
    rd_mode = 1;
    repeat (2000) @(negedge rd_clk);
    rd_mode = 2;
    settle(1);
    rd_mode = 2;
    repeat (80) @(negedge rd_clk);
    settle(12);
    chk(rd_idx == hist.size(), "R2 all delivered", 64'(rd_idx), 64'(hist.size()));

    // R3/R6: fill past full; offers while full are refused
    st = hist.size();
    wr_mode = 2;
    repeat (DEPTH + 40) @(negedge wr_clk);
    settle(12);
    chk(wr_ready == 0, "R3 full", 64'(wr_ready), 0);
    chk(hist.size() - st == DEPTH, "R3 accepted count", 64'(hist.size() - st), 64'(DEPTH));
    chk(almost_full == 1, "R6 almost_full at full", 64'(almost_full), 1);
    chk(almost_empty == 0, "R5 not almost_empty at full", 64'(almost_empty), 0);

    // R4: drain and keep requesting while empty
    rd_mode = 2;
    repeat (DEPTH + 40) @(negedge rd_clk);
    settle(12);
    chk(rd_valid == 0, "R4 empty", 64'(rd_valid), 0);
    chk(rd_idx == hist.size(), "R4 drained", 64'(rd_idx), 64'(hist.size()));
    chk(almost_empty == 1, "R5 almost_empty when empty", 64'(almost_empty), 1);

    // R5: threshold boundary
    write_n(AE);
    chk(almost_empty == 1, "R5 level == AE_LVL", 64'(almost_empty), 1);
    write_n(1);
    chk(almost_empty == 0, "R5 level == AE_LVL+1", 64'(almost_empty), 0);

    // R6: threshold boundary
    write_n(DEPTH - AF - 1 - (AE + 1));
    chk(almost_full == 0, "R6 free == AF_LVL+1", 64'(almost_full), 0);
    write_n(1);
    chk(almost_full == 1, "R6 free == AF_LVL", 64'(almost_full), 1);
    read_n(DEPTH - AF);
    chk(rd_valid == 0, "R4 empty again", 64'(rd_valid), 0);

    // R11: load outside retransmit is ignored
    write_n(6);
    read_n(2);
    st = hist.size() - 4;
    do_load();
    chk(rd_data == hist[st], "R11 load ignored", 64'(rd_data), 64'(hist[st]));
    read_n(4);

    // R7/R8/R12: replay after reading to empty
    write_n(10);
    st = rd_idx;
    rt_cmd = 1;
    settle(4);
    read_n(10);
    chk(rd_valid == 0, "R7 empty before load", 64'(rd_valid), 0);
    do_load();
    chk(rd_valid == 1, "R7 valid right after load", 64'(rd_valid), 1);
    chk(rd_data == hist[st], "R7 replay first word", 64'(rd_data), 64'(hist[st]));
    @(negedge rd_clk);
    @(negedge rd_clk);
    #1;
    chk(almost_empty == 0, "R8 almost_empty within two edges", 64'(almost_empty), 0);
    read_n(3);
    do_load();
    chk(rd_data == hist[st], "R12 second load same word", 64'(rd_data), 64'(hist[st]));
    rt_cmd = 0;
    read_n(10);
    chk(rd_valid == 0, "R4 empty after replay", 64'(rd_valid), 0);

    // R9/R10: shadow governs the write side until exit
    rt_cmd = 1;
    settle(4);
    wr_mode = 2;
    repeat (DEPTH + 20) @(negedge wr_clk);
    settle(12);
    read_n(DEPTH);
    settle(20);
    chk(rd_valid == 0, "R9 read all in mode", 64'(rd_valid), 0);
    chk(wr_ready == 0, "R9 space held by shadow", 64'(wr_ready), 0);
    chk(almost_full == 1, "R9 almost_full from shadow", 64'(almost_full), 1);
    rt_cmd = 0;
    @(negedge rd_clk);   // rt_mode driven low; exit edge follows
    @(posedge rd_clk);
    @(negedge wr_clk);
    #1;
    chk(wr_ready == 0, "R10 no release at first wr edge", 64'(wr_ready), 0);
    settle(DEPTH + 20);
    chk(wr_ready == 1, "R9 released after exit", 64'(wr_ready), 1);
    chk(almost_full == 0, "R9 almost_full cleared", 64'(almost_full), 0);

    // R2: random traffic again after retransmit use
    wr_mode = 1;
    rd_mode = 1;
    repeat (1000) @(negedge rd_clk);
    settle(1);
    rd_mode = 2;
    repeat (80) @(negedge rd_clk);
    settle(12);
    chk(rd_idx == hist.size(), "R2 final drain", 64'(rd_idx), 64'(hist.size()));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule